// File: doc/BRIEF.md
# No-Turnaround Pipelined Synchronous SRAM

A synthesizable behavioural model of a single-port synchronous SRAM whose shared data bus needs no idle cycle when the traffic switches between reads and writes. All controls are sampled on the rising clock edge. A write command's address and byte mask travel through delay registers, so its data arrives on the bus in the same relative slot that read data would occupy. Reads and writes can therefore be issued on every edge in any mix.

A load cycle takes a fresh external address and command. An advance cycle steps an internal two-bit burst counter, repeats the command of the last load, and produces the follow-on address in linear or interleaved order. A static strap picks the read latency. In flow-through timing the array output is driven in the cycle after the command. In pipelined timing it passes through an output register first, and arrives one cycle later. The pad's tri-state buffer lies outside this model. The block presents the outgoing data, a drive enable, and the incoming bus value as separate ports. The output-enable pin gates the drive enable combinationally. The array depth is a parameter, separate from the external address width, so that simulations can use a small memory.

Top module: `ntsr_top`

## Requirements
- R1: A cycle selects the device only when `ce0_n`=0, `ce1`=1 and `ce2_n`=0. A load cycle with any other combination is a deselect: it writes nothing, and `dq_oe` stays 0 in its data slot.
- R2: On a load cycle (`adv_ld`=0), `rd_wn`=1 issues a read and `rd_wn`=0 issues a write at `addr`.
- R3: With `flow_thru`=0 (pipelined), read data for a command sampled at edge k is on `dq_out` with `dq_oe`=1 from edge k+1 until edge k+2. Write data for a command sampled at edge k is taken from `dq_in` at edge k+2.
- R4: With `flow_thru`=1, read data for a command at edge k is driven from edge k until edge k+1. Write data for that command is taken from `dq_in` at edge k+1.
- R5: Byte lane i is bits [i*LANE_W +: LANE_W] of the data. A write changes lane i only when `bwe_n[i]`=0, and the other lanes keep their old contents.
- R6: In a linear burst (`lin_burst`=1 at the load), beat n has low address bits (a+n) mod 4, where a is the loaded low two bits. The upper address bits do not change.
- R7: In an interleaved burst (`lin_burst`=0 at the load), beat n has low address bits a XOR n. The upper address bits do not change.
- R8: An advance cycle repeats the operation of the most recent load, using the current `bwe_n`. An advance after a deselect is also a deselect, whatever the chip enables are.
- R9: While `cen_n`=1, every register holds, no array write occurs, and the driven bus value does not change.
- R10: `oe_n`=1 forces `dq_oe` to 0 at once, with no clock edge. `oe_n`=0 during a read data slot drives at once.
- R11: In pipelined timing, a read issued at the edge right after a write to the same address returns the write's new lanes merged with the array's other lanes.
- R12: `dq_oe` is 0 in the data slots of writes and of deselects, and after reset.
- R13: The burst counter wraps after four beats, so beat 4 addresses the same location as beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the command pipeline |
| cen_n | input | 1 | Active-low clock enable; high holds all state |
| ce0_n | input | 1 | Chip enable, active low |
| ce1 | input | 1 | Chip enable, active high |
| ce2_n | input | 1 | Chip enable, active low |
| rd_wn | input | 1 | 1 = read, 0 = write (load cycles) |
| bwe_n | input | LANES | Active-low byte-lane write enables |
| adv_ld | input | 1 | 0 = load new command, 1 = advance burst |
| lin_burst | input | 1 | 1 = linear burst order, 0 = interleaved |
| flow_thru | input | 1 | 1 = flow-through timing, 0 = pipelined (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | External word address |
| dq_in | input | LANES*LANE_W | Value present on the shared data bus |
| dq_out | output | LANES*LANE_W | Data the block drives onto the bus |
| dq_oe | output | 1 | Bus drive enable; 0 means high impedance |

## Verification
A corrupted burst counter or held command appears at the ports one data slot later. The wrong word, or a drive enable in the wrong state, shows up in the slot of the bad beat: one cycle after the advance in flow-through timing, two in pipelined. A stage-two register that loses its write address corrupts the array silently. That fault shows only when the location is next read, so the bench reads back every location it writes. A missed forwarding merge shows as stale lanes in the word that follows a write.

// File: rtl/ntsr_pkg.sv
package ntsr_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } ntsr_op_e;

   // low two address bits of burst beat 'beat' starting from 'start'
   function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                           input logic [1:0] beat,
                                           input logic       linear);
      return linear ? (start + beat) : (start ^ beat);
   endfunction

endpackage

// File: rtl/ntsr_seq.sv
// Command capture and burst address generation (first delay stage).
module ntsr_seq
   import ntsr_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sel,
   input  logic              rd,
   input  logic              adv,
   input  logic              linear,
   input  logic [LANES-1:0]  bwe_n,
   input  logic [ADDR_W-1:0] addr,
   output ntsr_op_e          op_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LANES-1:0]  mask_o
);

   initial assert (ADDR_W >= 3) else $error("ntsr_seq: ADDR_W must be at least 3");

   ntsr_op_e          held_op_q;
   logic [ADDR_W-1:0] base_q;
   logic [1:0]        beat_q;
   logic              lin_q;
   logic [1:0]        beat_nxt;
   ntsr_op_e          load_op;

   assign beat_nxt = beat_q + 2'd1;
   assign load_op  = !sel ? OP_NONE : (rd ? OP_RD : OP_WR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_op_q <= OP_NONE;
         op_o      <= OP_NONE;
         base_q    <= '0;
         beat_q    <= '0;
         lin_q     <= 1'b1;
         addr_o    <= '0;
         mask_o    <= '0;
      end else if (en) begin
         mask_o <= ~bwe_n;
         if (!adv) begin
            held_op_q <= load_op;
            op_o      <= load_op;
            base_q    <= addr;
            beat_q    <= '0;
            lin_q     <= linear;
            addr_o    <= addr;
         end else begin
            op_o   <= held_op_q;
            beat_q <= beat_nxt;
            addr_o <= {base_q[ADDR_W-1:2], beat_lsb(base_q[1:0], beat_nxt, lin_q)};
         end
      end
   end

   assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv && !sel) |=> (op_o == OP_NONE));

   assert_load_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !adv && sel) |=> (op_o == ($past(rd) ? OP_RD : OP_WR)));

   assert_linear_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && lin_q) |=> (addr_o[1:0] == $past(addr_o[1:0]) + 2'd1));

   assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv) |=> (addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2])));

   assert_interleave_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv && !lin_q) |=> ((addr_o[1:0] ^ base_q[1:0]) == beat_q));

   assert_inherit_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en && adv) |=> (op_o == $past(op_o)));

   assert_hold_s1_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(op_o) && $stable(addr_o) && $stable(mask_o)));

endmodule

// File: rtl/ntsr_dly.sv
// Second delay stage: carries a command one more edge for pipelined timing.
module ntsr_dly
   import ntsr_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  ntsr_op_e          op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [LANES-1:0]  mask_i,
   output ntsr_op_e          op_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LANES-1:0]  mask_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_o   <= OP_NONE;
         addr_o <= '0;
         mask_o <= '0;
      end else if (en) begin
         op_o   <= op_i;
         addr_o <= addr_i;
         mask_o <= mask_i;
      end
   end

   assert_stage_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ((op_o == $past(op_i)) && (addr_o == $past(addr_i))));

   assert_hold_s2_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(op_o) && $stable(addr_o) && $stable(mask_o)));

endmodule

// File: rtl/ntsr_array.sv
// Storage split into one memory per byte lane; asynchronous read port.
module ntsr_array #(
   parameter int AW     = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    we,
   input  logic [AW-1:0]           waddr,
   input  logic [LANES-1:0]        wmask,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [AW-1:0]           raddr,
   output logic [LANES*LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];

      always_ff @(posedge clk) begin
         if (we && wmask[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
      end

      assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
   end

endmodule

// File: rtl/ntsr_top.sv
module ntsr_top
   import ntsr_pkg::*;
#(
   parameter int ADDR_W   = 17,
   parameter int ARRAY_AW = 8,
   parameter int LANES    = 4,
   parameter int LANE_W   = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cen_n,
   input  logic                    ce0_n,
   input  logic                    ce1,
   input  logic                    ce2_n,
   input  logic                    rd_wn,
   input  logic [LANES-1:0]        bwe_n,
   input  logic                    adv_ld,
   input  logic                    lin_burst,
   input  logic                    flow_thru,
   input  logic                    oe_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] dq_in,
   output logic [LANES*LANE_W-1:0] dq_out,
   output logic                    dq_oe
);

   localparam int DATA_W = LANES * LANE_W;

   initial assert (LANE_W == 8 || LANE_W == 9) else $error("ntsr_top: LANE_W must be 8 or 9");
   initial assert (ARRAY_AW >= 2 && ARRAY_AW <= ADDR_W) else $error("ntsr_top: bad ARRAY_AW");
   initial assert (LANES >= 1) else $error("ntsr_top: LANES must be positive");

   logic en, sel;
   assign en  = ~cen_n;
   assign sel = ~ce0_n & ce1 & ~ce2_n;

   ntsr_op_e          s1_op, s2_op, d_op;
   logic [ADDR_W-1:0] s1_addr, s2_addr, d_addr;
   logic [LANES-1:0]  s1_mask, s2_mask, d_mask;

   ntsr_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .sel(sel), .rd(rd_wn), .adv(adv_ld),
      .linear(lin_burst), .bwe_n(bwe_n), .addr(addr),
      .op_o(s1_op), .addr_o(s1_addr), .mask_o(s1_mask)
   );

   ntsr_dly #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dly (
      .clk(clk), .rst_n(rst_n), .en(en),
      .op_i(s1_op), .addr_i(s1_addr), .mask_i(s1_mask),
      .op_o(s2_op), .addr_o(s2_addr), .mask_o(s2_mask)
   );

   // the stage whose data slot is on the bus now
   assign d_op   = flow_thru ? s1_op   : s2_op;
   assign d_addr = flow_thru ? s1_addr : s2_addr;
   assign d_mask = flow_thru ? s1_mask : s2_mask;

   logic              arr_we;
   logic [DATA_W-1:0] arr_rdata;

   assign arr_we = en && (d_op == OP_WR);

   ntsr_array #(.AW(ARRAY_AW), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk(clk), .we(arr_we), .waddr(d_addr[ARRAY_AW-1:0]), .wmask(d_mask),
      .wdata(dq_in), .raddr(s1_addr[ARRAY_AW-1:0]), .rdata(arr_rdata)
   );

   // pipelined timing: a write landing at the same edge the output register
   // loads a read of that word is forwarded lane by lane
   logic              fwd_hit;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] out_q;

   assign fwd_hit = (s2_op == OP_WR) && (s2_addr[ARRAY_AW-1:0] == s1_addr[ARRAY_AW-1:0]);

   for (genvar g = 0; g < LANES; g++) begin : g_fwd
      assign merged[g*LANE_W +: LANE_W] = (fwd_hit && s2_mask[g]) ?
                                          dq_in[g*LANE_W +: LANE_W] :
                                          arr_rdata[g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       out_q <= '0;
      else if (en && s1_op == OP_RD)    out_q <= merged;
   end

   assign dq_out = flow_thru ? arr_rdata : out_q;
   assign dq_oe  = ~oe_n & (d_op == OP_RD);

   assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !flow_thru) |=> $stable(out_q));

   assert_no_write_slot_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !flow_thru && s1_op == OP_WR) |=> !dq_oe);

endmodule

// File: tb/sim_ntsr_top.sv
module sim_ntsr_top;
   import ntsr_pkg::*;

   localparam int  AW   = 17;
   localparam int  DW   = 32;
   localparam time TCLK = 8ns;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cen_n, ce0_n, ce1, ce2_n, rd_wn, adv_ld, lin_burst, flow_thru, oe_n;
   logic [3:0]    bwe_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] dq_in, dq_out;
   logic          dq_oe;

   int checks = 0;
   int errors = 0;

   always #(TCLK/2) clk = ~clk;

   ntsr_top u0 (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce0_n(ce0_n), .ce1(ce1), .ce2_n(ce2_n),
      .rd_wn(rd_wn), .bwe_n(bwe_n), .adv_ld(adv_ld), .lin_burst(lin_burst),
      .flow_thru(flow_thru), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe)
   );

   typedef struct packed {
      logic          sel;
      logic          rd;
      logic          adv;
      logic [3:0]    bwn;
      logic [16:0]   a;
      logic [31:0]   wd;
      logic          expz;
      logic [31:0]   exp;
   } row_t;

   // pipelined; row i checks the data slot of row i-2 and supplies its write data
   localparam row_t TBL [12] = '{
      '{1'b1, 1'b0, 1'b0, 4'h0, 17'h10, 32'h0,        1'b1, 32'h0},        // W 0x10
      '{1'b1, 1'b0, 1'b0, 4'h0, 17'h11, 32'h0,        1'b1, 32'h0},        // W 0x11
      '{1'b1, 1'b1, 1'b0, 4'h0, 17'h10, 32'hA1A2A3A4, 1'b1, 32'h0},        // R 0x10
      '{1'b1, 1'b0, 1'b0, 4'hA, 17'h10, 32'hB1B2B3B4, 1'b1, 32'h0},        // W 0x10 lanes 0,2
      '{1'b1, 1'b1, 1'b0, 4'h0, 17'h10, 32'h0,        1'b0, 32'hA1A2A3A4}, // R 0x10 right after W (R11)
      '{1'b1, 1'b1, 1'b0, 4'h0, 17'h11, 32'hC1C2C3C4, 1'b1, 32'h0},        // R 0x11
      '{1'b0, 1'b1, 1'b0, 4'h0, 17'h12, 32'h0,        1'b0, 32'hA1C2A3C4}, // deselect
      '{1'b1, 1'b1, 1'b0, 4'h0, 17'h10, 32'h0,        1'b0, 32'hB1B2B3B4}, // R load 0x10
      '{1'b1, 1'b1, 1'b1, 4'h0, 17'h00, 32'h0,        1'b1, 32'h0},        // advance -> 0x11
      '{1'b0, 1'b1, 1'b0, 4'h0, 17'h00, 32'h0,        1'b0, 32'hA1C2A3C4},
      '{1'b0, 1'b1, 1'b0, 4'h0, 17'h00, 32'h0,        1'b0, 32'hB1B2B3B4},
      '{1'b0, 1'b1, 1'b0, 4'h0, 17'h00, 32'h0,        1'b1, 32'h0}
   };

   task automatic put(input logic sel, input logic rd, input logic adv,
                      input logic [3:0] bwn, input logic [AW-1:0] a, input logic [DW-1:0] wd);
      ce0_n  = ~sel;
      ce1    = 1'b1;
      ce2_n  = 1'b0;
      rd_wn  = rd;
      adv_ld = adv;
      bwe_n  = bwn;
      addr   = a;
      dq_in  = wd;
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_z(input string tag);
      checks++;
      if (dq_oe !== 1'b0) begin
         errors++;
         $display("FAIL %s: dq_oe=%b expected 0", tag, dq_oe);
      end
   endtask

   task automatic chk_v(input string tag, input logic [DW-1:0] exp);
      checks++;
      if (dq_oe !== 1'b1 || dq_out !== exp) begin
         errors++;
         $display("FAIL %s: dq_oe=%b dq_out=%h expected oe=1 data=%h", tag, dq_oe, dq_out, exp);
      end
   endtask

   function automatic logic [DW-1:0] vword(input int n);
      return 32'h11111111 * (n + 1);
   endfunction

   initial begin
      #(TCLK * 40000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cen_n = 1'b0; oe_n = 1'b0; flow_thru = 1'b0; lin_burst = 1'b1;
      put(1'b1, 1'b1, 1'b0, 4'h0, '0, '0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk_z("R12 reset");
      rst_n = 1'b1;

      // R8: advance straight after reset (nothing loaded) stays deselected
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc();
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0); cyc();
      chk_z("R8 advance after idle");
      cyc();

      // table: R1 R2 R3 R5 R6 R11 R12
      for (int i = 0; i < 12; i++) begin
         if (TBL[i].expz) chk_z($sformatf("R1/R3/R12 row %0d", i));
         else             chk_v($sformatf("R3/R5/R11 row %0d", i), TBL[i].exp);
         put(TBL[i].sel, TBL[i].rd, TBL[i].adv, TBL[i].bwn, TBL[i].a, TBL[i].wd);
         cyc();
      end

      // linear write burst 0x20..0x23 (R6, R8 inherits write)
      lin_burst = 1'b1;
      put(1'b1, 1'b0, 1'b0, 4'h0, 17'h20, '0);       cyc();
      put(1'b1, 1'b0, 1'b1, 4'h0, '0, '0);           cyc();
      put(1'b1, 1'b0, 1'b1, 4'h0, '0, vword(0));     cyc();
      put(1'b1, 1'b0, 1'b1, 4'h0, '0, vword(1));     cyc();
      put(1'b0, 1'b0, 1'b0, 4'h0, '0, vword(2));     cyc();
      put(1'b0, 1'b0, 1'b0, 4'h0, '0, vword(3));     cyc();

      // interleaved read burst from 0x21: 1,0,3,2 then wrap to 1 (R7, R13)
      lin_burst = 1'b0;
      put(1'b1, 1'b1, 1'b0, 4'h0, 17'h21, '0); cyc();
      lin_burst = 1'b1; // order is taken at the load only
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R7 beat0", vword(1));
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R7 beat1", vword(0));
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R7 beat2", vword(3));
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R7 beat3", vword(2));
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0); cyc(); chk_v("R13 interleaved wrap", vword(1));
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0); cyc(); chk_z("R12 after burst");

      // linear read burst from 0x21: 1,2,3,0 then wrap (R6, R13)
      put(1'b1, 1'b1, 1'b0, 4'h0, 17'h21, '0); cyc();
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R6 beat0", vword(1));
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R6 beat1", vword(2));
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R6 beat2", vword(3));
      put(1'b1, 1'b1, 1'b1, 4'h0, '0, '0); cyc(); chk_v("R6 beat3", vword(0));
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0); cyc(); chk_v("R13 linear wrap", vword(1));
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0); cyc(); chk_z("R1 deselect slot");

      // clock enable hold and asynchronous output enable (R9, R10)
      put(1'b1, 1'b1, 1'b0, 4'h0, 17'h20, '0); cyc();
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0);     cyc(); chk_v("R3 pipelined read", vword(0));
      cen_n = 1'b1;
      put(1'b1, 1'b1, 1'b0, 4'h0, 17'h23, '0); cyc(); chk_v("R9 hold keeps output", vword(0));
      oe_n = 1'b1; #1; chk_z("R10 oe off async");
      oe_n = 1'b0; #1; chk_v("R10 oe on async", vword(0));
      put(1'b1, 1'b0, 1'b0, 4'h0, 17'h22, 32'hFFFFFFFF); cyc(); cyc();
      cen_n = 1'b0;
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0);     cyc(); chk_z("R9 resume to deselect slot");
      put(1'b1, 1'b1, 1'b0, 4'h0, 17'h22, '0); cyc();
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0);     cyc(); chk_v("R9 held write ignored", vword(2));
      cyc();

      // flow-through timing (R4, R5, R12)
      flow_thru = 1'b1;
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0);     cyc(); cyc();
      put(1'b1, 1'b0, 1'b0, 4'h0, 17'h30, '0); cyc(); chk_z("R12 flow write slot");
      put(1'b1, 1'b1, 1'b0, 4'h0, 17'h30, 32'hDEADBEEF); cyc(); chk_v("R4 flow read", 32'hDEADBEEF);
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0);     cyc(); chk_z("R4 flow deselect slot");
      put(1'b1, 1'b0, 1'b0, 4'h7, 17'h30, '0); cyc();
      put(1'b1, 1'b1, 1'b0, 4'h0, 17'h30, 32'h00112233); cyc();
      chk_v("R5 flow single lane write", 32'h00ADBEEF);
      put(1'b0, 1'b1, 1'b0, 4'h0, '0, '0);     cyc();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule